// File: doc/BRIEF.md
# Signed Multiply/Divide Unit

This unit performs signed 16-bit arithmetic on a 32-bit accumulator pair, where B holds the high word and A the low word. A multiply sign-extends A and a 16-bit operand and returns the full signed product in B:A. A divide treats B:A as a signed 32-bit dividend, divides it by the operand, and returns the quotient in A and the remainder in B. An overflow flag reports whether the result fits.

The caller places the operation select, the operand and the current A and B words on the inputs, then raises `start` for one cycle. The unit captures everything on that edge. A multiply, or a divide that fails the overflow pre-check, finishes on the next cycle. Any other divide runs a restoring shift-subtract loop that resolves one quotient bit per clock. The outputs hold the last result until another operation completes.

Top module: `signed_muldiv`

## Requirements
- R1: With `opSel`=0 (multiply), the outputs become {bOut,aOut} = signed(aIn) × signed(operand) as a 32-bit two's complement value, with the high half in bOut.
- R2: A multiply always leaves `ovf` at 0.
- R3: With `opSel`=1 (divide) and no overflow, aOut holds the quotient truncated toward zero. bOut holds the remainder, whose magnitude is below the divisor magnitude and whose sign follows the dividend (a zero remainder stays 0).
- R4: A negative dividend is converted to its magnitude across both words, so a low word of zero borrows into the high word. For example, {B,A}=FFFF_0000 divided by 3 gives A=0xAAAB and B=0xFFFF.
- R5: When the high half of the dividend magnitude is greater than or equal to the divisor magnitude, `ovf` is set and aOut/bOut take the aIn/bIn values present at the start edge, unchanged.
- R6: A zero divisor always takes the R5 path.
- R7: After a nonzero quotient is negated for a negative quotient sign, `ovf` is set when the quotient's bit 15 differs from the expected sign, and the quotient and remainder are still written. For example, 0x0000_8000 / 1 gives ovf=1 and A=0x8000, while -32768 / 1 gives ovf=0.
- R8: `done` is high for exactly one cycle. It appears 1 cycle after the start edge for a multiply or a trapped divide, and WIDTH+2 cycles after it for a computed divide.
- R9: A `start` that arrives while a divide is running is ignored. It neither changes the result nor produces an extra `done`.
- R10: After reset, aOut, bOut, ovf and done are all 0.
- R11: Without `start`, changes on aIn, bIn and operand leave aOut, bOut and ovf unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch an operation (taken only when idle) |
| opSel | input | 1 | 0 = multiply, 1 = divide |
| operand | input | 16 | Multiplier or divisor |
| aIn | input | 16 | Current A word |
| bIn | input | 16 | Current B word |
| aOut | output | 16 | Result A word (product low / quotient) |
| bOut | output | 16 | Result B word (product high / remainder) |
| ovf | output | 1 | Overflow flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
A partial remainder that is not kept below the divisor corrupts the quotient. That error stays hidden during the loop and appears at the ports only on the finishing `done`, WIDTH+2 cycles after start. Extreme operands expose it: divisor 0x8000, and quotients near 0x8000. A wrong sign register or a wrong sign-correction step shows up on the same cycle, as a wrong quotient or remainder sign or a wrong `ovf`. A sequencing fault shows up as a `done` that arrives at the wrong cycle, repeats, or follows a start that should have been ignored.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_DIV = 1'b1
  } opSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic mulLoad;    // write product
    logic divTrap;    // pre-check overflow: keep inputs, flag ovf
    logic divLoad;    // capture magnitudes, start iteration
    logic divStep;    // one restoring quotient bit
    logic divFinish;  // apply signs, write result
  } ctlStrobes_t;

endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  opSel_e      opSel,
  input  logic        preOvf,
  output ctlStrobes_t ctl,
  output logic        done
);

  localparam int CW = $clog2(WIDTH);
  localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_FINISH = 2'd2
  } state_e;

  state_e        state, stateNext;
  logic [CW-1:0] stepCount;

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (opSel == OP_MUL) begin
            ctl.mulLoad = 1'b1;
          end else if (preOvf) begin
            ctl.divTrap = 1'b1;
          end else begin
            ctl.divLoad = 1'b1;
            stateNext   = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        ctl.divStep = 1'b1;
        if (stepCount == LAST_STEP) stateNext = ST_FINISH;
      end
      ST_FINISH: begin
        ctl.divFinish = 1'b1;
        stateNext     = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      stepCount <= '0;
      done      <= 1'b0;
    end else begin
      state <= stateNext;
      if (ctl.divLoad)      stepCount <= '0;
      else if (ctl.divStep) stepCount <= stepCount + CW'(1);
      done <= ctl.mulLoad | ctl.divTrap | ctl.divFinish;
    end
  end

  assert_strobe_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctl));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !(ctl.mulLoad || ctl.divLoad || ctl.divTrap));

  assert_finish_after_last_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FINISH) |-> ($past(state) == ST_RUN && $past(stepCount) == LAST_STEP));

endmodule

// File: rtl/muldiv_datapath.sv
module muldiv_datapath
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      ctl,
  input  logic [WIDTH-1:0] operand,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic             preOvf,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] bOut,
  output logic             ovf
);

  localparam int DW = 2 * WIDTH;

  // ---------- input conditioning ----------
  logic [DW-1:0]    dividend, dvdMag;
  logic [WIDTH-1:0] dvsMag;
  logic             dvdNeg, dvsNeg;
  logic [DW-1:0]    mulA, mulB, product;

  assign dividend = {bIn, aIn};
  assign dvdNeg   = bIn[WIDTH-1];
  assign dvsNeg   = operand[WIDTH-1];
  assign dvdMag   = dvdNeg ? (DW'(0) - dividend) : dividend;
  assign dvsMag   = dvsNeg ? (WIDTH'(0) - operand) : operand;
  assign preOvf   = (dvdMag[DW-1:WIDTH] >= dvsMag);

  assign mulA    = {{WIDTH{aIn[WIDTH-1]}}, aIn};
  assign mulB    = {{WIDTH{operand[WIDTH-1]}}, operand};
  assign product = mulA * mulB;

  // ---------- iterative divider state ----------
  logic [WIDTH:0]   remR;
  logic [WIDTH-1:0] quoR;
  logic [WIDTH-1:0] dvsR;
  logic             qSignR, rSignR;

  logic [WIDTH:0]   shifted, trial;
  assign shifted = {remR[WIDTH-1:0], quoR[WIDTH-1]};
  assign trial   = shifted - {1'b0, dvsR};

  // ---------- sign correction ----------
  logic [WIDTH-1:0] qSigned, rSigned;
  logic             quoNonZero, postOvf;
  assign quoNonZero = (quoR != '0);
  assign qSigned    = (qSignR && quoNonZero) ? (WIDTH'(0) - quoR) : quoR;
  assign rSigned    = rSignR ? (WIDTH'(0) - remR[WIDTH-1:0]) : remR[WIDTH-1:0];
  assign postOvf    = quoNonZero && (qSigned[WIDTH-1] != qSignR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR   <= '0;
      quoR   <= '0;
      dvsR   <= '0;
      qSignR <= 1'b0;
      rSignR <= 1'b0;
    end else if (ctl.divLoad) begin
      remR   <= {1'b0, dvdMag[DW-1:WIDTH]};
      quoR   <= dvdMag[WIDTH-1:0];
      dvsR   <= dvsMag;
      qSignR <= dvdNeg ^ dvsNeg;
      rSignR <= dvdNeg;
    end else if (ctl.divStep) begin
      if (!trial[WIDTH]) begin
        remR <= trial;
        quoR <= {quoR[WIDTH-2:0], 1'b1};
      end else begin
        remR <= shifted;
        quoR <= {quoR[WIDTH-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aOut <= '0;
      bOut <= '0;
      ovf  <= 1'b0;
    end else if (ctl.mulLoad) begin
      bOut <= product[DW-1:WIDTH];
      aOut <= product[WIDTH-1:0];
      ovf  <= 1'b0;
    end else if (ctl.divTrap) begin
      aOut <= aIn;
      bOut <= bIn;
      ovf  <= 1'b1;
    end else if (ctl.divFinish) begin
      aOut <= qSigned;
      bOut <= rSigned;
      ovf  <= postOvf;
    end
  end

  assert_rem_below_divisor_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.divStep || ctl.divFinish) |-> (remR < {1'b0, dvsR}));

  assert_trap_keeps_inputs_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.divTrap |=> (ovf && aOut == $past(aIn) && bOut == $past(bIn)));

  assert_mul_clears_ovf_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.mulLoad |=> !ovf);

  assert_rem_sign_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.divFinish |=> (bOut == '0 || bOut[WIDTH-1] == $past(rSignR)));

  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.mulLoad || ctl.divTrap || ctl.divFinish) |=> ($stable(aOut) && $stable(bOut) && $stable(ovf)));

endmodule

// File: rtl/signed_muldiv.sv
module signed_muldiv
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             opSel,
  input  logic [WIDTH-1:0] operand,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] bOut,
  output logic             ovf,
  output logic             done
);

  ctlStrobes_t ctl;
  logic        preOvf;

  muldiv_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .opSel  (opSel_e'(opSel)),
    .preOvf (preOvf),
    .ctl    (ctl),
    .done   (done)
  );

  muldiv_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .operand (operand),
    .aIn     (aIn),
    .bIn     (bIn),
    .preOvf  (preOvf),
    .aOut    (aOut),
    .bOut    (bOut),
    .ovf     (ovf)
  );

  assert_zero_divisor_traps_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.divLoad || ctl.divTrap) && operand == '0 |-> ctl.divTrap);

endmodule

// File: tb/signed_muldiv_tb.sv
module signed_muldiv_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        opSel = 1'b0;
  logic [15:0] operand = '0, aIn = '0, bIn = '0;
  logic [15:0] aOut, bOut;
  logic        ovf, done;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;  // 50 MHz

  signed_muldiv #(.WIDTH(16)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .operand(operand), .aIn(aIn), .bIn(bIn),
    .aOut(aOut), .bOut(bOut), .ovf(ovf), .done(done)
  );

  typedef struct packed {
    logic        op;
    logic [15:0] dvs;
    logic [15:0] a;
    logic [15:0] b;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 16'd5,     16'd3,     16'h0000},
    '{1'b0, 16'd7,     16'hFFFE,  16'h1234},
    '{1'b0, 16'h8000,  16'h8000,  16'h0000},
    '{1'b0, 16'hFFFF,  16'hFFFF,  16'h0000},
    '{1'b0, 16'h8000,  16'h7FFF,  16'h0000},
    '{1'b0, 16'd0,     16'h4321,  16'hFFFF},
    '{1'b1, 16'd7,     16'd100,   16'h0000},
    '{1'b1, 16'd7,     16'hFF9C,  16'hFFFF},
    '{1'b1, 16'hFFF9,  16'd100,   16'h0000},
    '{1'b1, 16'hFFF9,  16'hFF9C,  16'hFFFF},
    '{1'b1, 16'h8000,  16'h0000,  16'h0001},
    '{1'b1, 16'd1000,  16'h5678,  16'h0123},
    '{1'b1, 16'd12,    16'd24,    16'h0000},
    '{1'b1, 16'h7FFF,  16'hFFFF,  16'h7FFF}
  };

  function automatic logic isTrap(logic [15:0] dvs, logic [15:0] a, logic [15:0] b);
    longint dvd, dv, md, mv;
    dvd = longint'($signed({b, a}));
    dv  = longint'($signed(dvs));
    md  = (dvd < 0) ? -dvd : dvd;
    mv  = (dv < 0) ? -dv : dv;
    return ((md >>> 16) >= mv);
  endfunction

  // returns {ovf, B, A}
  function automatic logic [32:0] model(logic op, logic [15:0] dvs, logic [15:0] a, logic [15:0] b);
    longint p, dvd, dv, md, mv, q, r;
    logic [15:0] q16, r16;
    logic qs;
    if (!op) begin
      p = longint'($signed(a)) * longint'($signed(dvs));
      return {1'b0, p[31:0]};
    end
    if (isTrap(dvs, a, b)) return {1'b1, b, a};
    dvd = longint'($signed({b, a}));
    dv  = longint'($signed(dvs));
    md  = (dvd < 0) ? -dvd : dvd;
    mv  = (dv < 0) ? -dv : dv;
    q   = md / mv;
    r   = md % mv;
    qs  = (dvd < 0) != (dv < 0);
    q16 = q[15:0];
    if (qs && q16 != 0) q16 = -q16;
    r16 = r[15:0];
    if (dvd < 0) r16 = -r16;
    return {(q16 != 0) && (q16[15] != qs), r16, q16};
  endfunction

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic runCase(input logic op, input logic [15:0] dvs, input logic [15:0] a,
                         input logic [15:0] b, input string tag);
    logic [32:0] exp;
    int lat, expLat;
    @(negedge clk);
    opSel = op; operand = dvs; aIn = a; bIn = b; start = 1'b1;
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 100) begin
      @(posedge clk); lat++; @(negedge clk);
    end
    exp    = model(op, dvs, a, b);
    expLat = (!op || isTrap(dvs, a, b)) ? 1 : 18;
    check(aOut == exp[15:0],  tag, "aOut", 32'(aOut), 32'(exp[15:0]));
    check(bOut == exp[31:16], tag, "bOut", 32'(bOut), 32'(exp[31:16]));
    check(ovf == exp[32], op ? tag : "R2", "ovf", 32'(ovf), 32'(exp[32]));
    check(lat == expLat, "R8", "latency", 32'(lat), 32'(expLat));
    @(negedge clk);
    check(done == 1'b0, "R8", "done width", 32'(done), 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R10: reset state
    check(aOut == 0 && bOut == 0, "R10", "outputs", {aOut, bOut}, 32'd0);
    check(ovf == 0 && done == 0, "R10", "flags", 32'({ovf, done}), 32'd0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++)
      runCase(VECS[i].op, VECS[i].dvs, VECS[i].a, VECS[i].b, VECS[i].op ? "R3" : "R1");

    // R4: borrow across words for a negative dividend
    runCase(1'b1, 16'd3, 16'h0000, 16'hFFFF, "R4");
    check(aOut == 16'hAAAB && bOut == 16'hFFFF, "R4", "literal", {bOut, aOut}, 32'hFFFF_AAAB);
    // R5: high word >= divisor
    runCase(1'b1, 16'd5, 16'h1111, 16'h0005, "R5");
    runCase(1'b1, 16'hFFFB, 16'h2222, 16'hFFFA, "R5");
    // R6: zero divisor
    runCase(1'b1, 16'd0, 16'd10, 16'h0000, "R6");
    check(ovf == 1'b1, "R6", "ovf", 32'(ovf), 32'd1);
    // R7: post-sign overflow and its non-overflow neighbour
    runCase(1'b1, 16'd1, 16'h8000, 16'h0000, "R7");
    check(ovf == 1'b1 && aOut == 16'h8000, "R7", "pos", {15'd0, ovf, aOut}, 32'h1_8000);
    runCase(1'b1, 16'd1, 16'h8000, 16'hFFFF, "R7");
    check(ovf == 1'b0 && aOut == 16'h8000, "R7", "neg", {15'd0, ovf, aOut}, 32'h0_8000);

    // R9: start during a running divide is ignored
    begin
      int lat = 1;
      int dones = 0;
      @(negedge clk);
      opSel = 1'b1; operand = 16'd9; aIn = 16'd1000; bIn = 16'd0; start = 1'b1;
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      repeat (4) begin @(posedge clk); lat++; @(negedge clk); end
      opSel = 1'b0; operand = 16'd2; aIn = 16'd2; bIn = 16'd5; start = 1'b1;
      @(posedge clk); lat++; @(negedge clk);
      start = 1'b0;
      while (!done && lat < 100) begin @(posedge clk); lat++; @(negedge clk); end
      check(lat == 18, "R9", "latency", 32'(lat), 32'd18);
      check(aOut == 16'd111 && bOut == 16'd1 && !ovf, "R9", "result", {bOut, aOut}, {16'd1, 16'd111});
      repeat (4) begin @(posedge clk); @(negedge clk); if (done) dones++; end
      check(dones == 0, "R9", "extra done", 32'(dones), 32'd0);
    end

    // R11: no start, inputs wiggle, outputs hold
    begin
      logic [32:0] held;
      held = {ovf, bOut, aOut};
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        opSel = k[0]; operand = 16'(k * 77); aIn = 16'(k * 1234); bIn = 16'hFFFF;
      end
      repeat (3) @(negedge clk);
      check({ovf, bOut, aOut} == held && !done, "R11", "hold", {bOut, aOut}, held[31:0]);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule